// File: doc/BRIEF.md
# CPU Clock Level Sequencer

This block is a hardware state machine that moves the clock of a CPU domain from one of sixteen performance levels to another. Level 0 runs at 1700 MHz, and each higher index is 100 MHz slower, down to level 15 at 200 MHz. A request names the current level and the target level. The sequencer then drives, in a fixed order:

- the core clock mux select;
- the PLL configuration word and the lock-time value;
- the two clock-divider words.

Before each step it waits on the status pins for the mux, the dividers and the PLL lock. When the whole sequence has finished, it reports completion.

Each level has one PLL setting (M, P, S) and one set of divider values, held inside the block as constants. Direction decides the order of the two phases:

- **Speeding up:** the dividers move first, then the PLL.
- **Slowing down:** the PLL moves first, then the dividers.

When only S differs between the two levels, the sequencer rewrites only S. When M or P differs, the core is parked on the alternate clock source while the PLL relocks. Every status wait is bounded by a timeout that ends the sequence with an error flag.

The request port is a valid/ready pair with no back-pressure beyond `req_ready`. The rules are:

- `req_ready` is high exactly when the sequencer is idle.
- A request is taken on a rising edge where `req_valid` and `req_ready` are both high.
- `req_valid` raised while `req_ready` is low is dropped, not held.

Top module: `freq_step_seq`

## Requirements
- R1: Each level's PLL word places M in bits 25:16, P in bits 13:8 and S in bits 2:0. The (M,P,S) values by level 0..15 are (425,6,0) (200,3,0) (250,4,0) (175,3,0) (325,6,0) (200,4,0) (275,6,0) (125,3,0) (150,4,0) (100,3,0) (175,3,1) (200,4,1) (125,3,1) (100,3,1) (200,4,2) (100,3,2). After a successful sequence `pll_word` equals the target level's word.
- R2: `req_ready` is high only while `busy` is low. `busy` is high from the edge that accepts a request until the edge that raises `done`. `done` is a single-cycle pulse. A request offered while busy has no effect on the outcome.
- R3: A request whose old and new levels are equal raises `done` on the second edge after acceptance and changes no output word and no mux select.
- R4: When the new index is below the old one, the divider words are written and settled before `pll_word` changes.
- R5: When the new index is above the old one, `pll_word` changes before the divider words are written.
- R6: If M and P match between the old and new levels, only bits 2:0 of `pll_word` change, and `core_sel_alt` stays low.
- R7: If M or P differ, the relock runs in this order:
  1. Raise `core_sel_alt` and wait for `mux_stat` = 2.
  2. Load `lock_time` with P×`LOCK_MULT`, using the new level's P.
  3. Write M, P and S.
  4. Count `lock_time` cycles, then wait for `pll_locked`.
  5. Drop `core_sel_alt` and wait for `mux_stat` = 1.

  M and P change only while `core_sel_alt` is high.
- R8: The divider phase writes `div0_word` and waits until `div0_stat & 32'h11111111` is zero. It then writes `div1_word` and waits until `div1_stat & 8'h11` is zero. `div0_word` holds eight 3-bit fields at a 4-bit pitch (nibble 7..0). By level, the words are:
  - 0537_7730 (0), 0417_7730 (1), 0417_7720 (2), 0416_7720 (3), 0316_7720 (4), 0315_7720 (5), 0315_7730 (6)
  - 0214_7710 (7–9), 0113_7710 (10–11), 0112_7710 (12–13), 0111_7710 (14–15)

  `div1_word` is 0000_0020 for every level.
- R9: Any status wait lasting `WAIT_LIMIT` cycles ends the sequence with `err` high and a `done` pulse. The remaining steps are skipped.
- R10: Synchronous reset leaves the block in this state:
  - idle, with `busy`, `done` and `err` low;
  - `core_sel_alt` low;
  - `req_ready` high;
  - the output words set to level `RST_LEVEL`.
- R11: Bits of `pll_word` outside the M, P and S fields never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_old | input | 4 | Current level index |
| req_new | input | 4 | Target level index |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last sequence ended on a timeout |
| core_sel_alt | output | 1 | Core mux select, 1 = alternate source |
| mux_stat | input | 3 | Mux status: 1 main, 2 alternate, other values switching |
| pll_word | output | 32 | PLL configuration word |
| lock_time | output | LT_W | Lock wait in cycles |
| pll_locked | input | 1 | PLL lock flag |
| div0_word | output | 32 | First divider word |
| div0_stat | input | 32 | First divider status, busy bits under 32'h11111111 |
| div1_word | output | 32 | Second divider word |
| div1_stat | input | 8 | Second divider status, busy bits under 8'h11 |

## Verification
Timing of each result, counted from the accepting edge:

- `busy` rises on the accepting edge itself.
- A same-level request raises `done` one edge later, so the bench expects `done` at the second falling edge after that.
- Every other sequence finishes only after the status waits modelled by the bench. The bench therefore polls `done` at each falling edge and checks the final words in the cycle where it sees `done`.

Order and lock timing (R4, R5, R7) are checked by stamping, at falling edges, the cycle in which each output word, the mux select and the modelled divider state first change. The bench then compares the stamps. For R7 it checks that the gap from the M/P write to the mux return is at least `lock_time`.

// File: rtl/freq_step_pkg.sv
package freq_step_pkg;
  localparam int WORD_W       = 32;
  localparam int LVL_W        = 4;
  localparam int NUM_LEVELS   = 1 << LVL_W;
  localparam int M_W          = 10;
  localparam int M_LSB        = 16;
  localparam int P_W          = 6;
  localparam int P_LSB        = 8;
  localparam int S_W          = 3;
  localparam int MUX_W        = 3;
  localparam int DIV1_STAT_W  = 8;
  localparam int DIV_FIELD_W  = 3;
  localparam int DIV_PITCH    = 4;
  localparam int DIV0_FIELDS  = 8;
  localparam int DIV1_FIELDS  = 2;
  localparam logic [MUX_W-1:0] MUX_ON_MAIN = 3'd1;
  localparam logic [MUX_W-1:0] MUX_ON_ALT  = 3'd2;
  localparam logic [WORD_W-1:0] DIV0_MASK  = 32'h1111_1111;
  localparam logic [DIV1_STAT_W-1:0] DIV1_MASK = 8'h11;

  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic [M_W-1:0] m;
    logic [P_W-1:0] p;
    logic [S_W-1:0] s;
  } pms_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DIV0_WR, ST_DIV0_WAIT, ST_DIV1_WR, ST_DIV1_WAIT,
    ST_PLL_ENTRY, ST_S_WR, ST_ALT_WAIT, ST_LOCK_LOAD, ST_PLL_WR,
    ST_LOCK_COUNT, ST_LOCK_WAIT, ST_MAIN_SEL, ST_MAIN_WAIT, ST_FINISH
  } seq_state_e;

  function automatic pms_t level_pms(input lvl_t lvl);
    pms_t r;
    case (lvl)
      4'd0:    r = {10'd425, 6'd6, 3'd0};
      4'd1:    r = {10'd200, 6'd3, 3'd0};
      4'd2:    r = {10'd250, 6'd4, 3'd0};
      4'd3:    r = {10'd175, 6'd3, 3'd0};
      4'd4:    r = {10'd325, 6'd6, 3'd0};
      4'd5:    r = {10'd200, 6'd4, 3'd0};
      4'd6:    r = {10'd275, 6'd6, 3'd0};
      4'd7:    r = {10'd125, 6'd3, 3'd0};
      4'd8:    r = {10'd150, 6'd4, 3'd0};
      4'd9:    r = {10'd100, 6'd3, 3'd0};
      4'd10:   r = {10'd175, 6'd3, 3'd1};
      4'd11:   r = {10'd200, 6'd4, 3'd1};
      4'd12:   r = {10'd125, 6'd3, 3'd1};
      4'd13:   r = {10'd100, 6'd3, 3'd1};
      4'd14:   r = {10'd200, 6'd4, 3'd2};
      default: r = {10'd100, 6'd3, 3'd2};
    endcase
    return r;
  endfunction

  function automatic word_t pack_pll(input pms_t x);
    word_t w = '0;
    w[M_LSB +: M_W] = x.m;
    w[P_LSB +: P_W] = x.p;
    w[0 +: S_W]     = x.s;
    return w;
  endfunction

  // field index: 0 core, 1 core-data, 2 coherency, 3 periph, 4 trace bus,
  // 5 debug, 6 pll-out, 7 core-2
  function automatic logic [DIV_FIELD_W-1:0] div0_field(input lvl_t lvl, input int f);
    int l;
    logic [DIV_FIELD_W-1:0] v;
    l = int'(lvl);
    case (f)
      1: v = (l <= 1 || l == 6) ? 3'd3 : (l <= 5) ? 3'd2 : 3'd1;
      2, 3: v = 3'd7;
      4: v = (l <= 2) ? 3'd7 : (l <= 4) ? 3'd6 : (l <= 6) ? 3'd5 :
             (l <= 9) ? 3'd4 : (l <= 11) ? 3'd3 : (l <= 13) ? 3'd2 : 3'd1;
      5: v = (l == 0) ? 3'd3 : 3'd1;
      6: v = (l == 0) ? 3'd5 : (l <= 3) ? 3'd4 : (l <= 6) ? 3'd3 :
             (l <= 9) ? 3'd2 : 3'd1;
      default: v = 3'd0;
    endcase
    return v;
  endfunction

  function automatic logic [DIV_FIELD_W-1:0] div1_field(input int f);
    return (f == 1) ? 3'd2 : 3'd0;
  endfunction

  function automatic word_t pack_div0(input lvl_t lvl);
    word_t w = '0;
    for (int f = 0; f < DIV0_FIELDS; f++) w[f*DIV_PITCH +: DIV_FIELD_W] = div0_field(lvl, f);
    return w;
  endfunction

  function automatic word_t pack_div1();
    word_t w = '0;
    for (int f = 0; f < DIV1_FIELDS; f++) w[f*DIV_PITCH +: DIV_FIELD_W] = div1_field(f);
    return w;
  endfunction
endpackage

// File: rtl/fs_wait_timer.sv
module fs_wait_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt <= '0;
    else if (cnt != CW'(LIMIT)) cnt <= cnt + CW'(1);
  end

  assign expired_o = (cnt == CW'(LIMIT));
endmodule

// File: rtl/fs_lock_counter.sv
module fs_lock_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load_i) cnt <= value_i;
    else if (cnt != '0) cnt <= cnt - W'(1);
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/fs_level_rom.sv
module fs_level_rom
  import freq_step_pkg::*;
(
  input  lvl_t  lvl_i,
  output pms_t  pms_o,
  output word_t div0_o,
  output word_t div1_o
);
  localparam int PAD_W = DIV_PITCH - DIV_FIELD_W;

  assign pms_o = level_pms(lvl_i);

  for (genvar f = 0; f < DIV0_FIELDS; f++) begin : g_div0
    assign div0_o[f*DIV_PITCH +: DIV_PITCH] = {{PAD_W{1'b0}}, div0_field(lvl_i, f)};
  end

  for (genvar f = 0; f < DIV1_FIELDS; f++) begin : g_div1
    assign div1_o[f*DIV_PITCH +: DIV_PITCH] = {{PAD_W{1'b0}}, div1_field(f)};
  end
  assign div1_o[WORD_W-1:DIV1_FIELDS*DIV_PITCH] = '0;
endmodule

// File: rtl/freq_step_seq.sv
module freq_step_seq
  import freq_step_pkg::*;
#(
  parameter int WAIT_LIMIT = 1024,
  parameter int LOCK_MULT  = 250,
  parameter int LT_W       = 16,
  parameter int RST_LEVEL  = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [LVL_W-1:0]       req_old,
  input  logic [LVL_W-1:0]       req_new,
  output logic                   busy,
  output logic                   done,
  output logic                   err,
  output logic                   core_sel_alt,
  input  logic [MUX_W-1:0]       mux_stat,
  output logic [WORD_W-1:0]      pll_word,
  output logic [LT_W-1:0]        lock_time,
  input  logic                   pll_locked,
  output logic [WORD_W-1:0]      div0_word,
  input  logic [WORD_W-1:0]      div0_stat,
  output logic [WORD_W-1:0]      div1_word,
  input  logic [DIV1_STAT_W-1:0] div1_stat
);
  localparam lvl_t RST_LVL = lvl_t'(RST_LEVEL);

  seq_state_e st, after_pll, after_div;
  lvl_t       new_q;
  logic       up_q, second_q, relock_q;
  pms_t       new_pms, req_new_pms, req_old_pms;
  word_t      new_div0, new_div1;
  logic       in_wait, tmr_expired, lk_load, lk_zero;
  logic       div0_clear, div1_clear;

  fs_level_rom u_rom (
    .lvl_i  (new_q),
    .pms_o  (new_pms),
    .div0_o (new_div0),
    .div1_o (new_div1)
  );

  assign in_wait = st inside {ST_DIV0_WAIT, ST_DIV1_WAIT, ST_ALT_WAIT, ST_LOCK_WAIT, ST_MAIN_WAIT};

  fs_wait_timer #(.LIMIT(WAIT_LIMIT)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .run_i     (in_wait),
    .expired_o (tmr_expired)
  );

  assign lk_load = (st == ST_PLL_WR);

  fs_lock_counter #(.W(LT_W)) u_lock (
    .clk     (clk),
    .rst     (rst),
    .load_i  (lk_load),
    .value_i (lock_time),
    .zero_o  (lk_zero)
  );

  assign req_ready   = (st == ST_IDLE);
  assign req_new_pms = level_pms(req_new);
  assign req_old_pms = level_pms(req_old);
  assign div0_clear  = (div0_stat & DIV0_MASK) == '0;
  assign div1_clear  = (div1_stat & DIV1_MASK) == '0;
  assign after_pll   = (!up_q && !second_q) ? ST_DIV0_WR : ST_FINISH;
  assign after_div   = (up_q && !second_q) ? ST_PLL_ENTRY : ST_FINISH;

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      new_q        <= '0;
      up_q         <= 1'b0;
      second_q     <= 1'b0;
      relock_q     <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      err          <= 1'b0;
      core_sel_alt <= 1'b0;
      pll_word     <= pack_pll(level_pms(RST_LVL));
      div0_word    <= pack_div0(RST_LVL);
      div1_word    <= pack_div1();
      lock_time    <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            busy     <= 1'b1;
            err      <= 1'b0;
            new_q    <= req_new;
            up_q     <= (req_new < req_old);
            second_q <= 1'b0;
            relock_q <= {req_new_pms.m, req_new_pms.p} != {req_old_pms.m, req_old_pms.p};
            if (req_new == req_old)     st <= ST_FINISH;
            else if (req_new < req_old) st <= ST_DIV0_WR;
            else                        st <= ST_PLL_ENTRY;
          end
        end
        ST_DIV0_WR: begin
          div0_word <= new_div0;
          st        <= ST_DIV0_WAIT;
        end
        ST_DIV0_WAIT: begin
          if (div0_clear) st <= ST_DIV1_WR;
          else if (tmr_expired) begin err <= 1'b1; st <= ST_FINISH; end
        end
        ST_DIV1_WR: begin
          div1_word <= new_div1;
          st        <= ST_DIV1_WAIT;
        end
        ST_DIV1_WAIT: begin
          if (div1_clear) begin second_q <= 1'b1; st <= after_div; end
          else if (tmr_expired) begin err <= 1'b1; st <= ST_FINISH; end
        end
        ST_PLL_ENTRY: begin
          if (relock_q) begin core_sel_alt <= 1'b1; st <= ST_ALT_WAIT; end
          else st <= ST_S_WR;
        end
        ST_S_WR: begin
          pll_word[0 +: S_W] <= new_pms.s;
          second_q           <= 1'b1;
          st                 <= after_pll;
        end
        ST_ALT_WAIT: begin
          if (mux_stat == MUX_ON_ALT) st <= ST_LOCK_LOAD;
          else if (tmr_expired) begin err <= 1'b1; st <= ST_FINISH; end
        end
        ST_LOCK_LOAD: begin
          lock_time <= LT_W'(int'(new_pms.p) * LOCK_MULT);
          st        <= ST_PLL_WR;
        end
        ST_PLL_WR: begin
          pll_word[M_LSB +: M_W] <= new_pms.m;
          pll_word[P_LSB +: P_W] <= new_pms.p;
          pll_word[0 +: S_W]     <= new_pms.s;
          st                     <= ST_LOCK_COUNT;
        end
        ST_LOCK_COUNT: begin
          if (lk_zero) st <= ST_LOCK_WAIT;
        end
        ST_LOCK_WAIT: begin
          if (pll_locked) st <= ST_MAIN_SEL;
          else if (tmr_expired) begin err <= 1'b1; st <= ST_FINISH; end
        end
        ST_MAIN_SEL: begin
          core_sel_alt <= 1'b0;
          st           <= ST_MAIN_WAIT;
        end
        ST_MAIN_WAIT: begin
          if (mux_stat == MUX_ON_MAIN) begin second_q <= 1'b1; st <= after_pll; end
          else if (tmr_expired) begin err <= 1'b1; st <= ST_FINISH; end
        end
        ST_FINISH: begin
          busy <= 1'b0;
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fs_seq_checker.sv
module fs_seq_checker #(
  parameter int LT_W = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        core_sel_alt,
  input logic [31:0] pll_word,
  input logic [31:0] div0_word,
  input logic [31:0] div1_word,
  input logic [LT_W-1:0] lock_time
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R2

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_valid) |=> ($stable(pll_word) && $stable(div0_word) &&
                              $stable(div1_word) && $stable(core_sel_alt))); // R2

  AST_MP_ON_ALT: assert property (@(posedge clk) disable iff (rst)
    (pll_word[25:8] != $past(pll_word[25:8])) |-> core_sel_alt); // R7

  AST_MAIN_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !err) |-> !core_sel_alt); // R7

  AST_RESERVED_BITS: assert property (@(posedge clk) disable iff (rst)
    $stable({pll_word[31:26], pll_word[15:14], pll_word[7:3]})); // R11

  AST_LOCK_TIME_HELD: assert property (@(posedge clk) disable iff (rst)
    !core_sel_alt |=> (core_sel_alt || $stable(lock_time))); // R7
endmodule

bind freq_step_seq fs_seq_checker #(.LT_W(LT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .core_sel_alt (core_sel_alt),
  .pll_word     (pll_word),
  .div0_word    (div0_word),
  .div1_word    (div1_word),
  .lock_time    (lock_time)
);

// File: tb/freq_step_seq_tb.sv
`timescale 1ns/1ps
module freq_step_seq_tb;
  localparam int WAIT_LIMIT = 64;
  localparam int LOCK_MULT  = 250;
  localparam int LT_W       = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_old = '0, req_new = '0;
  logic        req_ready, busy, done, err, core_sel_alt, pll_locked;
  logic [2:0]  mux_stat;
  logic [31:0] pll_word, div0_word, div1_word, div0_stat;
  logic [7:0]  div1_stat;
  logic [LT_W-1:0] lock_time;

  freq_step_seq #(.WAIT_LIMIT(WAIT_LIMIT), .LOCK_MULT(LOCK_MULT), .LT_W(LT_W), .RST_LEVEL(0)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_old(req_old), .req_new(req_new), .busy(busy), .done(done), .err(err),
    .core_sel_alt(core_sel_alt), .mux_stat(mux_stat), .pll_word(pll_word),
    .lock_time(lock_time), .pll_locked(pll_locked), .div0_word(div0_word),
    .div0_stat(div0_stat), .div1_word(div1_word), .div1_stat(div1_stat)
  );

  // ---------------- status models ----------------
  bit stuck_div = 1'b0;
  logic [31:0] d0_app, d1_app, pll_seen;
  int d0_cnt, d1_cnt, mx_cnt, lk_cnt;
  logic alt_app;

  always @(posedge clk) begin
    if (rst) begin
      d0_app <= div0_word; d1_app <= div1_word; alt_app <= core_sel_alt;
      pll_seen <= pll_word; d0_cnt <= 0; d1_cnt <= 0; mx_cnt <= 0; lk_cnt <= 30;
    end else begin
      if (div0_word != d0_app && !stuck_div) begin
        if (d0_cnt == 4) begin d0_app <= div0_word; d0_cnt <= 0; end else d0_cnt <= d0_cnt + 1;
      end
      if (div1_word != d1_app) begin
        if (d1_cnt == 3) begin d1_app <= div1_word; d1_cnt <= 0; end else d1_cnt <= d1_cnt + 1;
      end
      if (core_sel_alt != alt_app) begin
        if (mx_cnt == 5) begin alt_app <= core_sel_alt; mx_cnt <= 0; end else mx_cnt <= mx_cnt + 1;
      end
      if (pll_word != pll_seen) begin pll_seen <= pll_word; lk_cnt <= 0; end
      else if (lk_cnt < 30) lk_cnt <= lk_cnt + 1;
    end
  end

  assign div0_stat  = ((div0_word != d0_app) ? 32'h0101_0010 : 32'h0) | 32'h2222_2222;
  assign div1_stat  = ((div1_word != d1_app) ? 8'h10 : 8'h0) | 8'hEE;
  assign mux_stat   = (core_sel_alt != alt_app) ? 3'd4 : (alt_app ? 3'd2 : 3'd1);
  assign pll_locked = (pll_word == pll_seen) && (lk_cnt >= 30);

  // ---------------- event monitor ----------------
  int cyc = 0;
  int t_div, t_pll, t_mp, t_back, t_d0app, alt_rises, n_changes;
  logic [31:0] p_pll, p_d0, p_d1, p_app;
  logic p_alt;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (!rst) begin
      if (div0_word != p_d0 && t_div < 0) t_div = cyc;
      if (pll_word != p_pll && t_pll < 0) t_pll = cyc;
      if (pll_word[25:8] != p_pll[25:8]) t_mp = cyc;
      if (core_sel_alt && !p_alt) alt_rises = alt_rises + 1;
      if (!core_sel_alt && p_alt) t_back = cyc;
      if (d0_app != p_app && t_d0app < 0) t_d0app = cyc;
      if (pll_word != p_pll || div0_word != p_d0 || div1_word != p_d1 || core_sel_alt != p_alt)
        n_changes = n_changes + 1;
    end
    p_pll = pll_word; p_d0 = div0_word; p_d1 = div1_word; p_alt = core_sel_alt; p_app = d0_app;
  end

  // ---------------- expected values ----------------
  function automatic logic [31:0] exp_pll(input int l);
    logic [18:0] r;
    case (l)
      0: r = {10'd425, 6'd6, 3'd0};   1: r = {10'd200, 6'd3, 3'd0};
      2: r = {10'd250, 6'd4, 3'd0};   3: r = {10'd175, 6'd3, 3'd0};
      4: r = {10'd325, 6'd6, 3'd0};   5: r = {10'd200, 6'd4, 3'd0};
      6: r = {10'd275, 6'd6, 3'd0};   7: r = {10'd125, 6'd3, 3'd0};
      8: r = {10'd150, 6'd4, 3'd0};   9: r = {10'd100, 6'd3, 3'd0};
      10: r = {10'd175, 6'd3, 3'd1};  11: r = {10'd200, 6'd4, 3'd1};
      12: r = {10'd125, 6'd3, 3'd1};  13: r = {10'd100, 6'd3, 3'd1};
      14: r = {10'd200, 6'd4, 3'd2};  default: r = {10'd100, 6'd3, 3'd2};
    endcase
    return {6'b0, r[18:9], 2'b0, r[8:3], 5'b0, r[2:0]};
  endfunction

  function automatic logic [31:0] exp_div0(input int l);
    if (l == 0) return 32'h0537_7730;
    if (l == 1) return 32'h0417_7730;
    if (l == 2) return 32'h0417_7720;
    if (l == 3) return 32'h0416_7720;
    if (l == 4) return 32'h0316_7720;
    if (l == 5) return 32'h0315_7720;
    if (l == 6) return 32'h0315_7730;
    if (l <= 9) return 32'h0214_7710;
    if (l <= 11) return 32'h0113_7710;
    if (l <= 13) return 32'h0112_7710;
    return 32'h0111_7710;
  endfunction

  // ---------------- check bookkeeping ----------------
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_req(input int o, input int n, input bit exp_err);
    int  wait_cnt;
    bit  relock;
    relock = exp_pll(o)[25:8] != exp_pll(n)[25:8];
    @(negedge clk);
    t_div = -1; t_pll = -1; t_mp = -1; t_back = -1; t_d0app = -1; alt_rises = 0; n_changes = 0;
    chk(req_ready == 1'b1, "R2", "ready while idle", req_ready, 1);
    req_valid = 1'b1; req_old = 4'(o); req_new = 4'(n);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
    wait_cnt = 0;
    while (!done && wait_cnt < 20000) begin
      if (wait_cnt == 3 && relock) begin
        chk(req_ready == 1'b0, "R2", "ready low while busy", req_ready, 0);
        req_valid = 1'b1; req_old = 4'(n); req_new = 4'((n + 5) % 16);
      end
      if (wait_cnt == 4) req_valid = 1'b0;
      @(negedge clk);
      wait_cnt++;
    end
    req_valid = 1'b0;
    chk(wait_cnt < 20000, "R2", "done seen", wait_cnt, 0);
    chk(err == exp_err, "R9", "error flag", err, exp_err);
    if (exp_err) begin
      chk(pll_word == exp_pll(o), "R9", "pll untouched after timeout", pll_word, exp_pll(o));
    end else begin
      chk(pll_word == exp_pll(n), "R1", "final pll word", pll_word, exp_pll(n));
      chk(div0_word == exp_div0(n), "R8", "final div0 word", div0_word, exp_div0(n));
      chk(div1_word == 32'h20, "R8", "final div1 word", div1_word, 32'h20);
      chk(core_sel_alt == 1'b0, "R7", "mux back on main", core_sel_alt, 0);
      if (o == n) begin
        chk(wait_cnt == 1, "R3", "same-level done latency", wait_cnt, 1);
        chk(n_changes == 0, "R3", "no output change", n_changes, 0);
      end else if (relock) begin
        chk(alt_rises == 1, "R7", "alternate select once", alt_rises, 1);
        chk(lock_time == LT_W'(exp_pll(n)[13:8] * LOCK_MULT), "R7", "lock time",
            lock_time, exp_pll(n)[13:8] * LOCK_MULT);
        chk(t_back - t_mp >= int'(lock_time), "R7", "lock interval", t_back - t_mp, lock_time);
      end else begin
        chk(alt_rises == 0, "R6", "no alternate select", alt_rises, 0);
        chk((pll_word & ~32'h7) == (exp_pll(o) & ~32'h7), "R6", "only S changed",
            pll_word, exp_pll(o));
      end
      if (t_div >= 0 && t_pll >= 0) begin
        if (n < o) begin
          chk(t_div < t_pll, "R4", "dividers before pll", t_div, t_pll);
          chk(t_d0app >= 0 && t_d0app <= t_pll, "R8", "div0 settled before pll", t_d0app, t_pll);
        end else begin
          chk(t_pll < t_div, "R5", "pll before dividers", t_pll, t_div);
        end
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R2", "done one cycle", done, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int cur;
    void'($urandom(32'd2024));
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0, "R10", "reset flags", {busy, done, err}, 0);
    chk(core_sel_alt == 0, "R10", "reset mux", core_sel_alt, 0);
    chk(req_ready == 1, "R10", "reset ready", req_ready, 1);
    chk(pll_word == exp_pll(0), "R10", "reset pll word", pll_word, exp_pll(0));
    chk(div0_word == exp_div0(0), "R10", "reset div0 word", div0_word, exp_div0(0));
    chk(div1_word == 32'h20, "R10", "reset div1 word", div1_word, 32'h20);

    cur = 0;
    run_req(0, 0, 0);    cur = 0;   // R3
    run_req(0, 15, 0);   cur = 15;  // R5 relock
    run_req(15, 9, 0);   cur = 9;   // R4 S only
    run_req(9, 13, 0);   cur = 13;  // R5 S only
    run_req(13, 9, 0);   cur = 9;
    run_req(9, 10, 0);   cur = 10;  // R7 relock despite adjacent
    run_req(10, 3, 0);   cur = 3;   // R6 raise, S only
    run_req(3, 0, 0);    cur = 0;   // R4 relock
    run_req(0, 5, 0);    cur = 5;
    run_req(5, 11, 0);   cur = 11;

    stuck_div = 1'b1;                // R9 timeout in divider wait
    run_req(11, 0, 1);
    stuck_div = 1'b0;
    repeat (20) @(negedge clk);
    run_req(11, 2, 0);   cur = 2;

    for (int i = 0; i < 24; i++) begin
      int n;
      n = $urandom_range(15, 0);
      run_req(cur, n, 0);
      cur = n;
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule